// File: doc/BRIEF.md
# Reload-Gated Down-Count Timer

This block is a down-counting period timer paired with an 8-bit repeat counter that thins out the event pulses sent towards interrupt logic. The timer counts down from a programmed period value and reloads when it reaches zero. It produces three kinds of event pulse: zero, load and compare. It also drives a PWM waveform, which is set by reloads and cleared by compare matches.

The repeat counter advances once per timer reload. When it has reached a programmed match value, the next reload returns it to zero and fires a repeat pulse. Two control bits work independently of each other. One withholds the zero and load pulses, and the other withholds the compare pulses, in any cycle where the repeat counter is nonzero. A long train of identical PWM periods can therefore raise one interrupt every N+1 periods.

The PWM generator always sees the ungated events, so the waveform does not depend on the suppression settings. A debug or fault halt freezes the timer, the repeat counter and the PWM level together.

Top module: `reload_gated_timer`

## Requirements
- R1: A synchronous active-low reset clears the timer count, the repeat count, all four event outputs and `pwm_out`. In the first non-halted edge where `enable` is high after being low, the count is loaded with `load_val`, `pwm_out` is set, and no event is raised.
- R2: Each non-halted edge with `enable` high after the start edge is a running edge. On a running edge the count drops by one, or is reloaded from `load_val` if it is zero. A reload edge makes `zero_evt` high for one cycle. `load_evt` is high for one cycle after the next non-halted edge. A running edge with the count equal to `cmp_val` makes `cmp_evt` high for one cycle.
- R3: The repeat count changes only on reload edges. On a reload edge it is cleared if it equals `rep_match`, and otherwise it is incremented modulo 256.
- R4: `rep_evt` is high for exactly one cycle after each reload edge at which the repeat count equalled `rep_match`.
- R5: With `sup_lz` high, `zero_evt` and `load_evt` stay low for any edge where the repeat count after that edge's update is nonzero.
- R6: With `sup_cmp` high, `cmp_evt` stays low for any edge where the updated repeat count is nonzero. This bit does not affect zero or load pulses, and `sup_lz` does not affect compare pulses.
- R7: `pwm_out` is set on a start or reload edge and cleared on a compare edge, with set winning when both occur. It ignores `sup_lz` and `sup_cmp`.
- R8: While `dbg_halt` or `fault_halt` is high, the count, the repeat count, `pwm_out` and the pending load pulse hold their values, and after the first halted edge no event output is high.
- R9: With `rep_match` = 4, `sup_lz` high and the repeat count starting at zero, exactly one of every five reloads lets its zero and load pulses through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| enable | input | 1 | Timer run enable; a rising level starts the timer from `load_val` |
| dbg_halt | input | 1 | Debug halt, freezes all state |
| fault_halt | input | 1 | Fault halt, freezes all state |
| load_val | input | CW | Period reload value |
| cmp_val | input | CW | Compare value for PWM and compare pulses |
| rep_match | input | RW | Repeat counter match value |
| sup_lz | input | 1 | Withhold zero/load pulses while repeat count is nonzero |
| sup_cmp | input | 1 | Withhold compare pulses while repeat count is nonzero |
| zero_evt | output | 1 | Gated zero event pulse |
| load_evt | output | 1 | Gated load event pulse |
| cmp_evt | output | 1 | Gated compare event pulse |
| rep_evt | output | 1 | Repeat-counter-zero pulse |
| pwm_out | output | 1 | PWM waveform from ungated events |

## Verification
The hardest situation to reach from the ports is a repeat count above the match value. In that case the counter must run through 255 and wrap to zero without raising a repeat pulse. It only happens when `rep_match` is lowered while the count is already past it. The random phase therefore rewrites `rep_match` with small values in the middle of a run, while the cycle-level reference model follows every step. A second hard case is a halt that arrives right after a reload, which leaves a load pulse pending across the halt. It is reached by making halts short and frequent, and by using short periods so that reloads fall close to them.

// File: rtl/rgt_pkg.sv
package rgt_pkg;
  localparam int unsigned RGT_CW = 16;
  localparam int unsigned RGT_RW = 8;

  typedef struct packed {
    logic zero;
    logic load;
    logic cmp;
  } rgt_evt_t;
endpackage

// File: rtl/rgt_count.sv
module rgt_count
  import rgt_pkg::*;
#(
  parameter int unsigned CW = RGT_CW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          halt,
  input  logic [CW-1:0] load_val,
  input  logic [CW-1:0] cmp_val,
  output rgt_evt_t      raw_evt,
  output logic          reload,
  output logic          pwm_out
);
  logic [CW-1:0] cnt_q;
  logic          en_q;
  logic          reload_q;
  logic          run, start, cmp_hit;

  assign run     = !halt && enable && en_q;
  assign start   = !halt && enable && !en_q;
  assign reload  = run && (cnt_q == '0);
  assign cmp_hit = run && (cnt_q == cmp_val);

  assign raw_evt.zero = reload;
  assign raw_evt.load = reload_q && !halt;
  assign raw_evt.cmp  = cmp_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      en_q     <= 1'b0;
      reload_q <= 1'b0;
      pwm_out  <= 1'b0;
    end else if (!halt) begin
      en_q     <= enable;
      reload_q <= reload;
      if (start)                cnt_q <= load_val;
      else if (run && reload)   cnt_q <= load_val;
      else if (run)             cnt_q <= cnt_q - 1'b1;
      if (start || reload)      pwm_out <= 1'b1;
      else if (cmp_hit)         pwm_out <= 1'b0;
    end
  end

  p_halt_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> $stable(cnt_q) && $stable(pwm_out) && $stable(reload_q));
  p_reload_val_r2: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> cnt_q == $past(load_val));
  p_down_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);
endmodule

// File: rtl/rgt_repeat.sv
module rgt_repeat
  import rgt_pkg::*;
#(
  parameter int unsigned RW = RGT_RW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reload,
  input  logic [RW-1:0] rep_match,
  output logic [RW-1:0] rc_next,
  output logic          rep_evt
);
  logic [RW-1:0] rc_q;
  logic          hit;

  assign hit = reload && (rc_q == rep_match);

  always_comb begin
    rc_next = rc_q;
    if (reload) rc_next = hit ? '0 : RW'(rc_q + 1'b1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rc_q    <= '0;
      rep_evt <= 1'b0;
    end else begin
      rc_q    <= rc_next;
      rep_evt <= hit;
    end
  end

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !reload |=> $stable(rc_q));
  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reload && rc_q != rep_match) |=> rc_q == RW'($past(rc_q) + 1'b1));
  p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reload && rc_q == rep_match) |=> rc_q == '0 && rep_evt);
  p_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !reload |=> !rep_evt);
endmodule

// File: rtl/rgt_gate.sv
module rgt_gate
  import rgt_pkg::*;
#(
  parameter int unsigned RW = RGT_RW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  rgt_evt_t      raw_evt,
  input  logic [RW-1:0] rc_next,
  input  logic          sup_lz,
  input  logic          sup_cmp,
  output rgt_evt_t      out_evt
);
  logic rc_zero, pass_lz, pass_cmp;

  assign rc_zero  = (rc_next == '0);
  assign pass_lz  = !sup_lz || rc_zero;
  assign pass_cmp = !sup_cmp || rc_zero;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_evt <= '0;
    end else begin
      out_evt.zero <= raw_evt.zero && pass_lz;
      out_evt.load <= raw_evt.load && pass_lz;
      out_evt.cmp  <= raw_evt.cmp && pass_cmp;
    end
  end

  p_block_lz_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sup_lz && rc_next != '0) |=> !out_evt.zero && !out_evt.load);
  p_block_cmp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sup_cmp && rc_next != '0) |=> !out_evt.cmp);
  p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !raw_evt.zero |=> !out_evt.zero);
endmodule

// File: rtl/reload_gated_timer.sv
module reload_gated_timer
  import rgt_pkg::*;
#(
  parameter int unsigned CW = RGT_CW,
  parameter int unsigned RW = RGT_RW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          dbg_halt,
  input  logic          fault_halt,
  input  logic [CW-1:0] load_val,
  input  logic [CW-1:0] cmp_val,
  input  logic [RW-1:0] rep_match,
  input  logic          sup_lz,
  input  logic          sup_cmp,
  output logic          zero_evt,
  output logic          load_evt,
  output logic          cmp_evt,
  output logic          rep_evt,
  output logic          pwm_out
);
  logic          halt;
  logic          reload;
  logic [RW-1:0] rc_next;
  rgt_evt_t      raw_evt, out_evt;

  assign halt = dbg_halt || fault_halt;

  rgt_count #(.CW(CW)) u_count (
    .clk(clk), .rst_n(rst_n), .enable(enable), .halt(halt),
    .load_val(load_val), .cmp_val(cmp_val),
    .raw_evt(raw_evt), .reload(reload), .pwm_out(pwm_out)
  );

  rgt_repeat #(.RW(RW)) u_repeat (
    .clk(clk), .rst_n(rst_n), .reload(reload), .rep_match(rep_match),
    .rc_next(rc_next), .rep_evt(rep_evt)
  );

  rgt_gate #(.RW(RW)) u_gate (
    .clk(clk), .rst_n(rst_n), .raw_evt(raw_evt), .rc_next(rc_next),
    .sup_lz(sup_lz), .sup_cmp(sup_cmp), .out_evt(out_evt)
  );

  assign zero_evt = out_evt.zero;
  assign load_evt = out_evt.load;
  assign cmp_evt  = out_evt.cmp;

  p_halt_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> !zero_evt && !cmp_evt && !rep_evt);
endmodule

// File: tb/reload_gated_timer_tb.sv
`timescale 1ns/1ps
module reload_gated_timer_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0, dbg_halt = 1'b0, fault_halt = 1'b0;
  logic [15:0] load_val = 16'd0, cmp_val = 16'd0;
  logic [7:0]  rep_match = 8'd0;
  logic sup_lz = 1'b0, sup_cmp = 1'b0;
  logic zero_evt, load_evt, cmp_evt, rep_evt, pwm_out;

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  reload_gated_timer u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .dbg_halt(dbg_halt),
    .fault_halt(fault_halt), .load_val(load_val), .cmp_val(cmp_val),
    .rep_match(rep_match), .sup_lz(sup_lz), .sup_cmp(sup_cmp),
    .zero_evt(zero_evt), .load_evt(load_evt), .cmp_evt(cmp_evt),
    .rep_evt(rep_evt), .pwm_out(pwm_out)
  );

  // behavioural reference model, updated at each rising edge
  int m_cnt, m_rc;
  bit m_enq, m_ldq, m_zero, m_load, m_cmp, m_rep, m_pwm;
  bit cmp_model_on = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_rc = 0; m_enq = 0; m_ldq = 0;
      m_zero = 0; m_load = 0; m_cmp = 0; m_rep = 0; m_pwm = 0;
    end else if (dbg_halt || fault_halt) begin
      m_zero = 0; m_load = 0; m_cmp = 0; m_rep = 0;
    end else begin
      bit run, start, rl, ch, plz, pc;
      int rcn;
      run   = enable && m_enq;
      start = enable && !m_enq;
      rl    = run && (m_cnt == 0);
      ch    = run && (m_cnt == int'(cmp_val));
      if (rl) rcn = (m_rc == int'(rep_match)) ? 0 : (m_rc + 1) % 256;
      else    rcn = m_rc;
      plz = !sup_lz || (rcn == 0);
      pc  = !sup_cmp || (rcn == 0);
      m_zero = rl && plz;
      m_load = m_ldq && plz;
      m_cmp  = ch && pc;
      m_rep  = rl && (m_rc == int'(rep_match));
      if (start || rl) m_pwm = 1;
      else if (ch)     m_pwm = 0;
      if (start)    m_cnt = int'(load_val);
      else if (rl)  m_cnt = int'(load_val);
      else if (run) m_cnt = m_cnt - 1;
      m_rc  = rcn;
      m_ldq = rl;
      m_enq = enable;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_model_on && rst_n) begin
      chk("R2/R5", "zero_evt", int'(zero_evt), int'(m_zero));
      chk("R2/R5", "load_evt", int'(load_evt), int'(m_load));
      chk("R2/R6", "cmp_evt",  int'(cmp_evt),  int'(m_cmp));
      chk("R3/R4", "rep_evt",  int'(rep_evt),  int'(m_rep));
      chk("R7",    "pwm_out",  int'(pwm_out),  int'(m_pwm));
    end
  end

  task automatic do_reset();
    rst_n = 1'b0; enable = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    int zc, lc, rc, cc;
    bit pw;
    do_reset();
    // R1 reset state
    chk("R1", "zero_evt reset", int'(zero_evt), 0);
    chk("R1", "load_evt reset", int'(load_evt), 0);
    chk("R1", "cmp_evt reset",  int'(cmp_evt), 0);
    chk("R1", "rep_evt reset",  int'(rep_evt), 0);
    chk("R1", "pwm_out reset",  int'(pwm_out), 0);
    cmp_model_on = 1'b1;

    // R9 directed: period 4 cycles, match 4, load/zero suppression
    load_val = 16'd3; cmp_val = 16'd1; rep_match = 8'd4; sup_lz = 1'b1; sup_cmp = 1'b0;
    enable = 1'b1;
    zc = 0; lc = 0; rc = 0; cc = 0;
    for (int i = 0; i < 210; i++) begin
      @(negedge clk);
      if (i == 0) begin
        chk("R1", "pwm set on start", int'(pwm_out), 1);
        chk("R1", "no event on start", int'(zero_evt | load_evt | cmp_evt | rep_evt), 0);
      end
      zc += int'(zero_evt); lc += int'(load_evt); rc += int'(rep_evt); cc += int'(cmp_evt);
    end
    chk("R9", "zero pulses in 52 reloads", zc, 10);
    chk("R9", "load pulses in 52 reloads", lc, 10);
    chk("R4", "repeat pulses in 52 reloads", rc, 10);
    chk("R6", "compare pulses unaffected by sup_lz", cc, 52);

    // R8 directed: fault halt freezes pwm, no events
    @(negedge clk); fault_halt = 1'b1;
    @(negedge clk); pw = pwm_out;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk("R8", "events quiet while halted", int'(zero_evt | load_evt | cmp_evt | rep_evt), 0);
      chk("R8", "pwm frozen while halted", int'(pwm_out), int'(pw));
    end
    fault_halt = 1'b0;

    // R6 directed: compare suppression only
    sup_lz = 1'b0; sup_cmp = 1'b1; rep_match = 8'd2;
    repeat (60) @(negedge clk);

    // random phase, reference model compared every cycle
    void'($urandom(32'd1234));
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if ($urandom_range(0, 19) == 0) load_val  = 16'($urandom_range(0, 7));
      if ($urandom_range(0, 19) == 0) cmp_val   = 16'($urandom_range(0, 8));
      if ($urandom_range(0, 29) == 0) rep_match = 8'($urandom_range(0, 6));
      if ($urandom_range(0, 39) == 0) sup_lz    = ~sup_lz;
      if ($urandom_range(0, 39) == 0) sup_cmp   = ~sup_cmp;
      dbg_halt   = ($urandom_range(0, 15) == 0);
      fault_halt = ($urandom_range(0, 31) == 0);
      if ($urandom_range(0, 99) == 0) enable = ~enable;
      else if (!enable && $urandom_range(0, 3) == 0) enable = 1'b1;
    end
    dbg_halt = 1'b0; fault_halt = 1'b0;
    repeat (5) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule